// File: doc/BRIEF.md
# Processor Presence Bitmap Window

This block keeps a presence map of processors, one bit per processor ID, and shows it to software as a small byte-addressed window. ID n lives in byte n/8 at bit n mod 8, so with the default of 256 IDs the window is 32 bytes long. At start-up the bits of the processors that are already fitted are loaded from a strap vector. Later each hot-add strobe carries an ID, sets that ID's bit and raises a sticky processor-hotplug flag in an event status byte.

The status byte is ANDed with an externally held enable byte to form the interrupt request. Software acknowledges the event by writing ones to the status byte through a separate clear strobe. The window accepts writes, but they change nothing, so no presence bit can ever be cleared other than by reset. An add whose ID lies outside the map is dropped and sets a sticky error flag.

Reset is asserted asynchronously and released through a two-stage synchronizer. The strap vector is copied into the map on the first clock edge after the internal reset is released.

Top module: `proc_presence_win`

## Requirements
- R1: The map covers IDs 0 to NUM_IDS-1 (default 256). The byte offsets 0 to NUM_IDS/8-1 (default 0 to 31) are all readable, and ID NUM_IDS-1 appears as bit 7 of the last offset.
- R2: ID n is held at byte offset n/8, bit n mod 8. `reg_rdata` shows the byte at `reg_addr` combinationally, in the same cycle.
- R3: A write through `reg_wr`/`reg_wdata` changes no bit of the map, whether the written data holds ones or zeros. No map bit ever goes from 1 to 0 except through reset.
- R4: While reset is asserted, every byte of the map reads 0x00, and `evt_status`, `irq` and `add_err` are all 0.
- R5: On the third rising clock edge after `rst_n` goes high, the map loads `init_present`. Before that edge it reads all zero.
- R6: If `add_vld` is high at a rising edge with `add_id` < NUM_IDS, then after that edge the ID's bit is set and bit 2 (value 0x04) of `evt_status` is 1. All other status bits always read 0.
- R7: When `evt_clr` is high at an edge with `evt_clr_mask` bit 2 set, the hotplug flag clears. A mask with bit 2 at 0 leaves the flag alone. An add in the same cycle wins, and the flag stays set.
- R8: `irq` is 1 exactly when `evt_status & evt_en` is non-zero. It follows in the same cycle as the status or the enable changes.
- R9: An add with `add_id` >= NUM_IDS (the id is 9 bits wide) changes neither the map nor the status. It sets `add_err`, which then stays 1 until reset.
- R10: An add for an ID whose bit is already set still sets the hotplug flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_present | input | NUM_IDS | Strap vector of processors fitted at start-up |
| add_vld | input | 1 | Hot-add strobe |
| add_id | input | ID_W (9) | Processor ID carried by the hot-add |
| reg_addr | input | ADDR_W (5) | Byte offset into the window |
| reg_wr | input | 1 | Window write strobe (no effect) |
| reg_wdata | input | 8 | Window write data (no effect) |
| reg_rdata | output | 8 | Byte of the map at reg_addr |
| evt_clr | input | 1 | Status write-one-to-clear strobe |
| evt_clr_mask | input | 8 | Status bits to clear |
| evt_en | input | 8 | Event enable byte |
| evt_status | output | 8 | Event status byte, hotplug flag at bit 2 |
| irq | output | 1 | Interrupt request |
| add_err | output | 1 | Sticky out-of-range add flag |

## Verification
The map is loaded from a sparse strap pattern, and reads at single-bit offsets separate a correct byte/bit split from a swapped or shifted one. Directed adds at the top ID, a repeated ID, out-of-range IDs that alias onto real bits, and an add coinciding with a clear separate the set, duplicate, drop and priority rules. Window writes of all-ones and all-zeros show whether writes can set or clear map bits. A long random run mixes adds, clears, enable changes, writes and sweeping read offsets, and a behavioural model is compared with every output on every cycle.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned EVT_W       = 8;
  localparam int unsigned HP_FLAG_BIT = 2;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ppb_rst_sync.sv
module ppb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/ppb_bitmap.sv
module ppb_bitmap #(
  parameter int unsigned NUM_IDS = 256,
  parameter int unsigned ID_W    = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] init_present,
  input  logic               add_vld,
  input  logic [ID_W-1:0]    add_id,
  output logic [NUM_IDS-1:0] map_q,
  output logic               add_ok,
  output logic               add_bad
);
  localparam int unsigned IDX_W = $clog2(NUM_IDS);

  logic               init_done_q;
  logic [NUM_IDS-1:0] map_d;
  logic               map_en;
  logic               in_range;

  assign in_range = (add_id < ID_W'(NUM_IDS));
  assign add_ok   = add_vld && in_range;
  assign add_bad  = add_vld && !in_range;

  always_comb begin
    map_d = init_done_q ? map_q : init_present;
    if (add_ok) map_d[add_id[IDX_W-1:0]] = 1'b1;
    map_en = !init_done_q || add_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q       <= '0;
      init_done_q <= 1'b0;
    end else begin
      init_done_q <= 1'b1;
      if (map_en) map_q <= map_d;
    end
  end

  // R3: once loaded, no bit of the map falls
  p_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_q |=> ((map_q & $past(map_q)) == $past(map_q)));

  // R6: a valid add leaves its bit set
  p_add_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (add_ok && init_done_q) |=> map_q[$past(add_id[IDX_W-1:0])]);

  // R9: an out-of-range add leaves the map untouched
  p_bad_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (add_bad && init_done_q) |=> $stable(map_q));
endmodule

// File: rtl/ppb_event.sv
module ppb_event
  import ppb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_hp,
  input  logic             set_err,
  input  logic             clr_vld,
  input  logic [EVT_W-1:0] clr_mask,
  input  logic [EVT_W-1:0] en,
  output logic [EVT_W-1:0] status,
  output logic             irq,
  output logic             err
);
  logic hp_q, hp_d, hp_en;
  logic err_q, err_d, err_en;

  always_comb begin
    hp_en  = set_hp || clr_vld;
    hp_d   = set_hp || (hp_q && !(clr_vld && clr_mask[HP_FLAG_BIT]));
    err_en = set_err;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (hp_en)  hp_q  <= hp_d;
      if (err_en) err_q <= err_d;
    end
  end

  always_comb begin
    status              = '0;
    status[HP_FLAG_BIT] = hp_q;
  end

  assign irq = |(status & en);
  assign err = err_q;

  // R7: an add in the same cycle as a clear keeps the flag
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_hp |=> status[HP_FLAG_BIT]);

  // R7: a clear with the flag bit set and no add drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && clr_mask[HP_FLAG_BIT] && !set_hp) |=> !status[HP_FLAG_BIT]);

  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: no interrupt without an enable bit
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en));
endmodule

// File: rtl/ppb_rd_mux.sv
module ppb_rd_mux
  import ppb_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 32,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] map,
  input  logic [ADDR_W-1:0]           addr,
  output byte_t                       rdata
);
  byte_t bytes [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign bytes[b] = map[b*BYTE_W +: BYTE_W];
  end

  assign rdata = bytes[addr];
endmodule

// File: rtl/proc_presence_win.sv
module proc_presence_win
  import ppb_pkg::*;
#(
  parameter int unsigned NUM_IDS   = 256,
  localparam int unsigned NUM_BYTES = NUM_IDS / BYTE_W,
  localparam int unsigned ADDR_W    = $clog2(NUM_BYTES),
  localparam int unsigned ID_W      = $clog2(NUM_IDS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] init_present,
  input  logic               add_vld,
  input  logic [ID_W-1:0]    add_id,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               evt_clr,
  input  logic [7:0]         evt_clr_mask,
  input  logic [7:0]         evt_en,
  output logic [7:0]         evt_status,
  output logic               irq,
  output logic               add_err
);
  logic               rst_sync_n;
  logic [NUM_IDS-1:0] map;
  logic               add_ok;
  logic               add_bad;

  ppb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ppb_bitmap #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_map (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .init_present (init_present),
    .add_vld      (add_vld),
    .add_id       (add_id),
    .map_q        (map),
    .add_ok       (add_ok),
    .add_bad      (add_bad)
  );

  ppb_event u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_hp   (add_ok),
    .set_err  (add_bad),
    .clr_vld  (evt_clr),
    .clr_mask (evt_clr_mask),
    .en       (evt_en),
    .status   (evt_status),
    .irq      (irq),
    .err      (add_err)
  );

  ppb_rd_mux #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_rd (
    .map   (map),
    .addr  (reg_addr),
    .rdata (reg_rdata)
  );

  // R3: writing ones into the window sets nothing
  p_wr_ones_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && (|reg_wdata) && !add_vld && $past(rst_sync_n)) |=> $stable(map));

  // R3: writing zeros into the window clears nothing
  p_wr_zeros_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && !(|reg_wdata) && !add_vld && $past(rst_sync_n)) |=> $stable(map));
endmodule

// File: tb/tb_proc_presence_win.sv
`timescale 1ns/1ps
module tb_proc_presence_win;
  localparam int N  = 256;
  localparam int NB = N / 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] init_present;
  logic         add_vld;
  logic [8:0]   add_id;
  logic [4:0]   reg_addr;
  logic         reg_wr;
  logic [7:0]   reg_wdata;
  logic [7:0]   reg_rdata;
  logic         evt_clr;
  logic [7:0]   evt_clr_mask;
  logic [7:0]   evt_en;
  logic [7:0]   evt_status;
  logic         irq;
  logic         add_err;

  always #4 clk = ~clk;

  proc_presence_win dut (
    .clk(clk), .rst_n(rst_n), .init_present(init_present),
    .add_vld(add_vld), .add_id(add_id), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_clr(evt_clr), .evt_clr_mask(evt_clr_mask), .evt_en(evt_en),
    .evt_status(evt_status), .irq(irq), .add_err(add_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference
  bit ref_map [N];
  int ref_sync = 0;
  bit ref_init = 0;
  bit ref_hp = 0;
  bit ref_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (ref_map[i]) ref_map[i] = 0;
      ref_sync = 0; ref_init = 0; ref_hp = 0; ref_err = 0;
    end else if (ref_sync < 2) begin
      ref_sync++;
    end else begin
      bit good;
      good = add_vld && (int'(add_id) < N);
      if (!ref_init) begin
        for (int i = 0; i < N; i++) ref_map[i] = init_present[i];
        ref_init = 1;
      end
      if (good) ref_map[int'(add_id)] = 1;
      if (add_vld && !good) ref_err = 1;
      if (good) ref_hp = 1;
      else if (evt_clr && evt_clr_mask[2]) ref_hp = 0;
    end
  end

  function automatic logic [7:0] ref_byte(int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = ref_map[k*8 + i];
    return v;
  endfunction

  function automatic logic [7:0] ref_status();
    return ref_hp ? 8'h04 : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(reg_rdata == ref_byte(int'(reg_addr)), "R2 read byte", reg_rdata, ref_byte(int'(reg_addr)));
      chk(evt_status == ref_status(), "R6 status", evt_status, ref_status());
      chk(irq == |(ref_status() & evt_en), "R8 irq", irq, |(ref_status() & evt_en));
      chk(add_err == ref_err, "R9 err", add_err, ref_err);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    add_vld = 0; reg_wr = 0; evt_clr = 0;
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  initial begin
    rst_n = 0; add_vld = 0; add_id = '0; reg_addr = '0; reg_wr = 0;
    reg_wdata = '0; evt_clr = 0; evt_clr_mask = '0; evt_en = '0;
    init_present = '0;
    init_present[0] = 1; init_present[1] = 1; init_present[9] = 1;
    init_present[63] = 1; init_present[200] = 1;
    cyc(3);
    // R4 reset state
    chk(reg_rdata == 8'h00, "R4 reset read", reg_rdata, 0);
    chk(evt_status == 8'h00 && !irq && !add_err, "R4 reset status", {evt_status, irq, add_err}, 0);

    rst_n = 1;
    settle(); settle();
    chk(reg_rdata == 8'h00, "R5 map empty before load edge", reg_rdata, 0);
    settle();
    chk(reg_rdata == 8'h03, "R5 strap loaded byte0", reg_rdata, 3);
    cyc(1); reg_addr = 5'd1;
    #1 chk(reg_rdata == 8'h02, "R2 id9 at byte1 bit1", reg_rdata, 2);
    reg_addr = 5'd7;
    #1 chk(reg_rdata == 8'h80, "R2 id63 at byte7 bit7", reg_rdata, 8'h80);
    reg_addr = 5'd25;
    #1 chk(reg_rdata == 8'h01, "R2 id200 at byte25 bit0", reg_rdata, 1);

    // R1 top ID
    cyc(1); add_vld = 1; add_id = 9'd255; reg_addr = 5'd31;
    cyc(1); idle();
    #1 chk(reg_rdata == 8'h80, "R1 id255 at byte31 bit7", reg_rdata, 8'h80);
    chk(evt_status == 8'h04, "R6 hotplug flag 0x04", evt_status, 4);
    chk(irq == 0, "R8 irq masked", irq, 0);
    evt_en = 8'h04;
    #1 chk(irq == 1, "R8 irq enabled", irq, 1);
    evt_en = 8'hFB;
    #1 chk(irq == 0, "R8 irq other enables", irq, 0);
    evt_en = 8'h04;

    // R7 clear behaviour
    cyc(1); evt_clr = 1; evt_clr_mask = 8'hFB;
    cyc(1); idle();
    #1 chk(evt_status == 8'h04, "R7 mask without bit2 no effect", evt_status, 4);
    evt_clr = 1; evt_clr_mask = 8'h04;
    cyc(1); idle();
    #1 chk(evt_status == 8'h00 && !irq, "R7 clear drops flag", evt_status, 0);
    add_vld = 1; add_id = 9'd100; evt_clr = 1; evt_clr_mask = 8'hFF;
    cyc(1); idle();
    #1 chk(evt_status == 8'h04, "R7 add wins over clear", evt_status, 4);
    evt_clr = 1; evt_clr_mask = 8'h04;
    cyc(1); idle();

    // R10 duplicate add
    add_vld = 1; add_id = 9'd9; reg_addr = 5'd1;
    cyc(1); idle();
    #1 chk(evt_status == 8'h04, "R10 duplicate add raises flag", evt_status, 4);
    chk(reg_rdata == 8'h02, "R10 byte unchanged", reg_rdata, 2);
    evt_clr = 1; evt_clr_mask = 8'h04;
    cyc(1); idle();

    // R3 writes ignored
    reg_wr = 1; reg_addr = 5'd1; reg_wdata = 8'h00;
    cyc(1); idle();
    #1 chk(reg_rdata == 8'h02, "R3 zero write keeps bits", reg_rdata, 2);
    reg_wr = 1; reg_addr = 5'd2; reg_wdata = 8'hFF;
    cyc(1); idle();
    #1 chk(reg_rdata == 8'h00, "R3 ones write sets nothing", reg_rdata, 0);

    // R9 out-of-range adds
    add_vld = 1; add_id = 9'd300; reg_addr = 5'd5;
    cyc(1); idle();
    #1 chk(add_err == 1, "R9 err set", add_err, 1);
    chk(evt_status == 8'h00, "R9 no flag", evt_status, 0);
    chk(reg_rdata == 8'h00, "R9 alias byte5 untouched", reg_rdata, 0);
    add_vld = 1; add_id = 9'd256; reg_addr = 5'd0;
    cyc(1); idle();
    #1 chk(evt_status == 8'h00 && reg_rdata == 8'h03, "R9 id256 dropped", {evt_status, reg_rdata}, 3);
    cyc(5);
    chk(add_err == 1, "R9 err sticky", add_err, 1);

    // random mix
    for (int t = 0; t < 2000; t++) begin
      add_vld      = ($urandom_range(0, 3) == 0);
      add_id       = 9'($urandom_range(0, 270));
      evt_clr      = ($urandom_range(0, 4) == 0);
      evt_clr_mask = 8'($urandom);
      evt_en       = 8'($urandom);
      reg_wr       = ($urandom_range(0, 2) == 0);
      reg_wdata    = 8'($urandom);
      reg_addr     = 5'($urandom);
      cyc(1);
    end
    idle();
    cyc(2);

    // R4 mid-run reset
    #1 rst_n = 0;
    #1 reg_addr = 5'd0;
    #1 chk(reg_rdata == 8'h00 && evt_status == 8'h00 && !irq && !add_err,
           "R4 async reset clears", {reg_rdata, evt_status, irq, add_err}, 0);
    cyc(2);
    rst_n = 1;
    cyc(5);
    chk(reg_rdata == 8'h03, "R5 reload after reset", reg_rdata, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule